// File: doc/BRIEF.md
# CPU Idle Mode Controller

This block controls the low-power idle state of a processor core. It holds a power control register that software writes through a simple write strobe. Software writes a 1 to the idle-select bit to ask for idle. The core is not halted at once: the controller waits until the core reports, on its retire strobe, that the setting instruction has finished. It then raises a registered halt output, which gates the CPU clock or freezes fetch. Peripheral clocks are not touched, and register and memory contents stay as they are.

Idle ends in one of two ways. The first is an interrupt request whose enable bit is set. This clears the idle-select bit and drops the halt, so the core takes the interrupt and then continues with the instruction after the one that set the bit. The second is a reset, either the external synchronous reset or a watchdog timeout while the watchdog is enabled. A reset clears all state and then gives a one-cycle pulse that tells the core to load its reset vector (address zero).

Top module: `idle_ctl`

## Requirements
- R1: While `rst` is high, `rd_data` is 0 and `cpu_halt` is 0. `vec_load` is high for exactly the one cycle after the first clock edge at which no reset source is active.
- R2: A write (`wr_en`=1) while not halted stores `wr_data` into the power control register, readable on `rd_data` after that edge. Bit 0 is the idle-select bit, and a 1 there requests idle.
- R3: `cpu_halt` rises only on an edge at which `retire` is high and idle is requested, either by the register or by a write in the same cycle. While halted, bit 0 reads 1.
- R4: In idle, any request bit with its enable bit set clears `cpu_halt` and bit 0 on the next edge. The other register bits keep their value.
- R5: Interrupt requests whose enable bit is 0 do not end idle.
- R6: If an enabled request is pending on the retiring edge, `cpu_halt` stays 0 and bit 0 is cleared.
- R7: Register writes made while `cpu_halt` is 1 are ignored.
- R8: Writing bit 0 as 0 before the retire strobe withdraws the request, and a later retire does not halt.
- R9: A watchdog request with `wdt_en`=1 clears the register and the halt on the next edge and is followed by a `vec_load` pulse. With `wdt_en`=0 the request is ignored.
- R10: The external reset ends idle, clears the register, and is followed by a `vec_load` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU domain clock |
| rst | input | 1 | Synchronous active-high external reset |
| wr_en | input | 1 | Power control register write strobe |
| wr_data | input | DW | Write data; bit 0 is idle-select |
| rd_data | output | DW | Power control register contents |
| retire | input | 1 | Instruction-retired strobe from the core |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-line interrupt enable bits |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_req | input | 1 | Watchdog timeout reset request |
| cpu_halt | output | 1 | Registered CPU clock-gate / halt |
| vec_load | output | 1 | One-cycle reset-vector load pulse |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around its rising edge. They also assume that the core never reports a retire while halted, although the design ignores one anyway. The bench changes inputs just after the falling edge, so every input is settled a half period before the next rising edge. The only retire strobes it issues are the ones that a running core could produce. It holds interrupt lines for several cycles and also raises them on the same cycle as a retire. This covers both the steady-idle wake and the zero-length idle case.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ARMED = 2'd1,
    ST_IDLE  = 2'd2
  } idle_state_e;

  localparam int SEL_BIT = 0;
endpackage

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
  parameter int NIRQ = 8
) (
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            wake
);
  logic [NIRQ-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NIRQ; gi++) begin : g_line
      assign hit[gi] = irq_req[gi] & irq_en[gi];
    end
  endgenerate

  assign wake = |hit;
endmodule

// File: rtl/idle_reset_seq.sv
module idle_reset_seq (
  input  logic clk,
  input  logic rst,
  input  logic wdt_en,
  input  logic wdt_req,
  output logic sreset,
  output logic vec_load
);
  logic rst_d;

  assign sreset = rst | (wdt_en & wdt_req);

  always_ff @(posedge clk) begin
    if (sreset) begin
      rst_d    <= 1'b1;
      vec_load <= 1'b0;
    end else begin
      rst_d    <= 1'b0;
      vec_load <= rst_d;
    end
  end
endmodule

// File: rtl/idle_pcon_reg.sv
module idle_pcon_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          sreset,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          sel_clr,
  output logic [DW-1:0] q
);
  import idle_ctl_pkg::*;

  always_ff @(posedge clk) begin
    if (sreset) begin
      q <= '0;
    end else begin
      if (wr_stb) q <= wr_data;
      if (sel_clr) q[SEL_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm (
  input  logic clk,
  input  logic sreset,
  input  logic wr_set,
  input  logic wr_clr,
  input  logic retire,
  input  logic wake,
  output logic sel_clr,
  output logic halt
);
  import idle_ctl_pkg::*;

  idle_state_e st, nxt;

  always_comb begin
    nxt     = st;
    sel_clr = 1'b0;
    case (st)
      ST_RUN: begin
        if (wr_set) begin
          if (retire) begin
            if (wake) begin
              nxt     = ST_RUN;
              sel_clr = 1'b1;
            end else begin
              nxt = ST_IDLE;
            end
          end else begin
            nxt = ST_ARMED;
          end
        end
      end
      ST_ARMED: begin
        if (wr_clr) begin
          nxt = ST_RUN;
        end else if (retire) begin
          if (wake) begin
            nxt     = ST_RUN;
            sel_clr = 1'b1;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (wake) begin
          nxt     = ST_RUN;
          sel_clr = 1'b1;
        end
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sreset) begin
      st   <= ST_RUN;
      halt <= 1'b0;
    end else begin
      st   <= nxt;
      halt <= (nxt == ST_IDLE);
    end
  end
endmodule

// File: rtl/idle_ctl.sv
module idle_ctl #(
  parameter int DW   = 8,
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic            retire,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            wdt_en,
  input  logic            wdt_req,
  output logic            cpu_halt,
  output logic            vec_load
);
  import idle_ctl_pkg::*;

  logic sreset, wake, sel_clr, wr_stb, wr_set, wr_clr;

  assign wr_stb = wr_en & ~cpu_halt;
  assign wr_set = wr_stb & wr_data[SEL_BIT];
  assign wr_clr = wr_stb & ~wr_data[SEL_BIT];

  idle_reset_seq u_rst (
    .clk(clk), .rst(rst), .wdt_en(wdt_en), .wdt_req(wdt_req),
    .sreset(sreset), .vec_load(vec_load)
  );

  idle_wake_detect #(.NIRQ(NIRQ)) u_wake (
    .irq_req(irq_req), .irq_en(irq_en), .wake(wake)
  );

  idle_fsm u_fsm (
    .clk(clk), .sreset(sreset), .wr_set(wr_set), .wr_clr(wr_clr),
    .retire(retire), .wake(wake), .sel_clr(sel_clr), .halt(cpu_halt)
  );

  idle_pcon_reg #(.DW(DW)) u_pcon (
    .clk(clk), .sreset(sreset), .wr_stb(wr_stb), .wr_data(wr_data),
    .sel_clr(sel_clr), .q(rd_data)
  );
endmodule

// File: rtl/idle_ctl_chk.sv
module idle_ctl_chk #(
  parameter int DW   = 8,
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [DW-1:0]   wr_data,
  input logic [DW-1:0]   rd_data,
  input logic            retire,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] irq_en,
  input logic            wdt_en,
  input logic            wdt_req,
  input logic            cpu_halt,
  input logic            vec_load
);
  logic woke, wdog;
  assign woke = |(irq_req & irq_en);
  assign wdog = wdt_en & wdt_req;

  a_r1_vec_single: assert property (@(posedge clk) disable iff (rst)
    vec_load |=> !vec_load);

  a_r3_halt_needs_retire: assert property (@(posedge clk) disable iff (rst)
    (!cpu_halt && !retire) |=> !cpu_halt);

  a_r3_halt_has_sel: assert property (@(posedge clk) disable iff (rst)
    cpu_halt |-> rd_data[0]);

  a_r4_wake_clears: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && woke) |=> (!cpu_halt && !rd_data[0]));

  a_r5_disabled_no_wake: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && !woke && !wdog) |=> cpu_halt);

  a_r7_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (cpu_halt && !woke && !wdog) |=> $stable(rd_data));

  a_r9_wdt_clears: assert property (@(posedge clk) disable iff (rst)
    wdog |=> (!cpu_halt && rd_data == '0 && !vec_load));
endmodule

bind idle_ctl idle_ctl_chk #(.DW(DW), .NIRQ(NIRQ)) u_chk (.*);

// File: tb/idle_ctl_test.sv
module idle_ctl_test;
  localparam int DW = 8;
  localparam int NIRQ = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic retire = 1'b0;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NIRQ-1:0] irq_en = '0;
  logic wdt_en = 1'b0;
  logic wdt_req = 1'b0;
  logic cpu_halt, vec_load;

  always #4 clk = ~clk;

  idle_ctl #(.DW(DW), .NIRQ(NIRQ)) uut (.*);

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  logic [DW-1:0] m_reg = '0;
  int m_st = 0;
  logic m_halt = 1'b0;
  logic m_vec = 1'b0;
  logic m_rstd = 1'b1;

  always @(posedge clk) begin
    bit wake, armed;
    wake = 1'b0;
    for (int i = 0; i < NIRQ; i++) if (irq_req[i] && irq_en[i]) wake = 1'b1;
    if (rst || (wdt_en && wdt_req)) begin
      m_reg = '0; m_st = 0; m_halt = 1'b0; m_vec = 1'b0; m_rstd = 1'b1;
    end else begin
      m_vec = m_rstd; m_rstd = 1'b0;
      if (m_st == 2) begin
        if (wake) begin m_st = 0; m_reg[0] = 1'b0; end
      end else begin
        if (wr_en) m_reg = wr_data;
        armed = m_reg[0];
        if (armed && retire) begin
          if (wake) begin m_reg[0] = 1'b0; m_st = 0; end
          else m_st = 2;
        end else begin
          m_st = armed ? 1 : 0;
        end
      end
      m_halt = (m_st == 2);
    end
  end

  always @(negedge clk) begin
    checks++;
    if (rd_data !== m_reg || cpu_halt !== m_halt || vec_load !== m_vec) begin
      errors++;
      $display("FAIL %s: rd_data=%h halt=%b vec=%b expected rd_data=%h halt=%b vec=%b",
               tag, rd_data, cpu_halt, vec_load, m_reg, m_halt, m_vec);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected <=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [DW-1:0] d, bit ret);
    wr_en = 1'b1; wr_data = d; retire = ret;
    idle(1);
    wr_en = 1'b0; retire = 1'b0;
  endtask

  task automatic ret1();
    retire = 1'b1; idle(1); retire = 1'b0;
  endtask

  initial begin
    tag = "R1"; idle(3); rst = 1'b0; idle(4);
    tag = "R2"; wr(8'hA4, 0); idle(2); wr(8'h5A, 1); idle(2); wr(8'h00, 0); idle(2);
    tag = "R3"; wr(8'h31, 0); idle(3); ret1(); idle(2);
    tag = "R5"; irq_req = 8'h0F; irq_en = 8'hF0; idle(4);
    tag = "R7"; wr(8'h00, 0); wr(8'hFE, 0); idle(2);
    tag = "R4"; irq_en = 8'h08; idle(3); irq_req = '0; irq_en = '0; idle(2);
    tag = "R3"; wr(8'h81, 1); idle(3);
    tag = "R4"; irq_req = 8'h80; irq_en = 8'h80; idle(2);
    tag = "R6"; irq_req = 8'h02; irq_en = 8'h02; wr(8'h01, 0); ret1(); idle(2);
    wr(8'h11, 1); idle(2); irq_req = '0; irq_en = '0; idle(2);
    tag = "R8"; wr(8'h01, 0); idle(1); wr(8'h40, 0); ret1(); idle(3);
    tag = "R9"; wr(8'h07, 1); idle(2);
    wdt_req = 1'b1; idle(2); wdt_req = 1'b0; idle(1);
    wdt_en = 1'b1; wdt_req = 1'b1; idle(1); wdt_req = 1'b0; idle(4); wdt_en = 1'b0;
    tag = "R10"; wr(8'h25, 0); ret1(); idle(2); rst = 1'b1; idle(2); rst = 1'b0; idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule